// File: doc/BRIEF.md
# Host-to-DSP Mailbox Port

This block joins a byte-wide host processor bus to a 24-bit signal-processing core. The host sees eight byte registers: interrupt control, command vector, status, interrupt vector, an unused slot and a three-byte data window. Each direction has a single-word mailbox. A pair of empty/full flags controls the mailbox, one flag on the side that fills it and one on the side that drains it. A word moves across in the same cycle in which both flags allow it. A host interrupt request is raised from the status flags and the enables in the control register. An acknowledge returns the stored vector, or a spurious indication when no request is pending.

After reset the port is in boot mode. In this mode every word the host completes goes to a program-memory write port at consecutive addresses. When the last boot word has been written, the port leaves boot mode and asserts a run signal to the core. The host bus can issue a multi-byte access as a chain of byte accesses. Each continuation byte adds a fixed number of wait cycles, and during those cycles the port accepts no access.

Top module: `host_mailbox_port`

## Requirements
- R1: After reset, status (offset 2) reads 0x06, the core status `dsp_hsr` is 0x02, the vector register (offset 3) reads 0x0F, and run, busy and interrupt request are all low.
- R2: Host offsets are 0 control, 1 command vector, 2 status, 3 vector, 4 unused, and 5/6/7 the high/middle/low data bytes. Offset 4 always reads 0. Writes to offsets 2 and 4 have no effect. Offsets 1 and 3 read back the value written.
- R3: A control write is stored with bit 2 forced to 0. Control bits 3 and 4 appear on `dsp_hsr` bits 3 and 4.
- R4: Outside boot mode, a host write to offset 7 completes the word {off5, off6, off7} and clears the transmit-empty flag (status bit 1). A write to offset 5 or 6 alone leaves that flag unchanged. If the receive-full flag (`dsp_hsr` bit 0) is clear, the word moves to `dsp_hrx` in the same cycle, receive-full sets and transmit-empty sets again.
- R5: While receive-full is set, a completed host word waits with transmit-empty clear. A core read (`dsp_rd_hrx`) clears receive-full, and in that same cycle the waiting word moves into `dsp_hrx`.
- R6: A core write of `dsp_htx_wdata` clears transmit-empty on the core side (`dsp_hsr` bit 1). If the host receive-full flag (status bit 0) is clear, the word is split onto offsets 5/6/7 in the same cycle, and both flags set.
- R7: While host receive-full is set, a core word waits. A host read of offset 7 outside boot mode clears host receive-full and moves the waiting word across in the same cycle.
- R8: Status bit 2 equals transmit-empty AND NOT receive-full.
- R9: In boot mode, each completed host word is written to program memory one cycle later, at addresses counting up from 0. `dsp_hrx` and receive-full are left untouched, and transmit-empty stays set.
- R10: The boot-word write at address BOOT_WORDS-1 (default 512) ends boot mode and raises `dsp_run`, which then stays high. Later words follow R4.
- R11: In boot mode, a host read of offset 7 does not clear host receive-full.
- R12: The request equals (control bit 0 AND host receive-full) OR (control bit 1 AND transmit-empty). An acknowledge returns the vector register while the request is high, and raises the spurious flag with vector 0 while it is low.
- R13: An accepted access with `hst_cont` high holds `hst_busy` for exactly WAIT_CYC (default 4) cycles. Accesses during those cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host byte access strobe, one per cycle |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_cont | input | 1 | Access continues a multi-byte access |
| hst_addr | input | 3 | Host register offset |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte for `hst_addr` |
| hst_busy | output | 1 | Wait penalty in progress |
| hst_irq | output | 1 | Host interrupt request |
| hst_iack | input | 1 | Interrupt acknowledge |
| hst_iack_vec | output | 8 | Vector returned on acknowledge |
| hst_iack_spur | output | 1 | Acknowledge with no request pending |
| dsp_rd_hrx | input | 1 | Core reads the receive word |
| dsp_hrx | output | 24 | Receive word toward the core |
| dsp_wr_htx | input | 1 | Core writes a transmit word |
| dsp_htx_wdata | input | 24 | Transmit word from the core |
| dsp_hsr | output | 8 | Core status: bit0 receive-full, bit1 transmit-empty, bits 3/4 host flags |
| dsp_run | output | 1 | Boot finished, core may run |
| pmem_we | output | 1 | Program-memory write strobe |
| pmem_addr | output | 9 | Program-memory write address |
| pmem_wdata | output | 24 | Program-memory write word |

## Verification
The bench goes after the same-cycle hand-offs: a core read that frees the mailbox while a host word waits, and a host low-byte read that frees it while a core word waits. A design that moved the word only on the next host or core action would leave it stranded, and a status flag would show it. The bench runs all 512 boot words. A boot counter that was off by one would raise run one word early or late, or would route a word to the receive register. The bench also checks that a low-byte read during boot leaves receive-full set, that an access issued during the wait penalty has no effect, and that an acknowledge with no request returns the spurious flag instead of a stale vector.

// File: rtl/host_mailbox_port.sv
module host_mailbox_port #(
  parameter int          BOOT_WORDS = 512,
  parameter int          WAIT_CYC   = 4,
  parameter logic [7:0]  IVR_RST    = 8'h0F,
  localparam int         WORD_W     = 24,
  localparam int         PA_W       = (BOOT_WORDS > 2) ? $clog2(BOOT_WORDS) : 1,
  localparam int         WC_W       = $clog2(WAIT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic              hst_cont,
  input  logic [2:0]        hst_addr,
  input  logic [7:0]        hst_wdata,
  output logic [7:0]        hst_rdata,
  output logic              hst_busy,
  output logic              hst_irq,
  input  logic              hst_iack,
  output logic [7:0]        hst_iack_vec,
  output logic              hst_iack_spur,
  input  logic              dsp_rd_hrx,
  output logic [WORD_W-1:0] dsp_hrx,
  input  logic              dsp_wr_htx,
  input  logic [WORD_W-1:0] dsp_htx_wdata,
  output logic [7:0]        dsp_hsr,
  output logic              dsp_run,
  output logic              pmem_we,
  output logic [PA_W-1:0]   pmem_addr,
  output logic [WORD_W-1:0] pmem_wdata
);

  logic [7:0]        icr, cvr, ivr, tx_h, tx_m;
  logic [WORD_W-1:0] tx_word, hrx, htx, rx_word;
  logic              txde, rxdf, hrdf, htde, boot;
  logic [PA_W-1:0]   boot_addr;
  logic [WC_W-1:0]   wait_cnt;

  logic              acc, wr_lo, rd_lo, boot_wr, boot_last;
  logic [WORD_W-1:0] wr_word, pend_word, htx_n;
  logic              txde_a, hrdf_a, htde_a, rxdf_a, h2d, d2h;

  assign hst_busy  = (wait_cnt != '0);
  assign acc       = hst_sel & ~hst_busy;
  assign wr_lo     = acc & hst_wr & (hst_addr == 3'd7);
  assign rd_lo     = acc & ~hst_wr & (hst_addr == 3'd7);
  assign wr_word   = {tx_h, tx_m, hst_wdata};
  assign boot_wr   = wr_lo & boot;
  assign boot_last = (boot_addr == PA_W'(BOOT_WORDS - 1));

  assign txde_a    = (wr_lo & ~boot) ? 1'b0 : txde;
  assign pend_word = (wr_lo & ~boot) ? wr_word : tx_word;
  assign hrdf_a    = dsp_rd_hrx ? 1'b0 : hrdf;
  assign h2d       = ~txde_a & ~hrdf_a;

  assign htde_a    = dsp_wr_htx ? 1'b0 : htde;
  assign htx_n     = dsp_wr_htx ? dsp_htx_wdata : htx;
  assign rxdf_a    = (rd_lo & ~boot) ? 1'b0 : rxdf;
  assign d2h       = ~htde_a & ~rxdf_a;

  assign dsp_hrx   = hrx;
  assign dsp_hsr   = {3'b000, icr[4], icr[3], 1'b0, htde, hrdf};
  assign dsp_run   = ~boot;
  assign hst_irq   = (icr[0] & rxdf) | (icr[1] & txde);
  assign hst_iack_vec  = (hst_iack & hst_irq) ? ivr : 8'h00;
  assign hst_iack_spur = hst_iack & ~hst_irq;

  always_comb begin
    case (hst_addr)
      3'd0:    hst_rdata = icr;
      3'd1:    hst_rdata = cvr;
      3'd2:    hst_rdata = {5'b0, txde & ~hrdf, txde, rxdf};
      3'd3:    hst_rdata = ivr;
      3'd5:    hst_rdata = rx_word[23:16];
      3'd6:    hst_rdata = rx_word[15:8];
      3'd7:    hst_rdata = rx_word[7:0];
      default: hst_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icr <= '0;
      cvr <= '0;
      ivr <= IVR_RST;
      tx_h <= '0;
      tx_m <= '0;
    end else if (acc & hst_wr) begin
      case (hst_addr)
        3'd0: icr  <= hst_wdata & 8'hFB;
        3'd1: cvr  <= hst_wdata;
        3'd3: ivr  <= hst_wdata;
        3'd5: tx_h <= hst_wdata;
        3'd6: tx_m <= hst_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txde    <= 1'b1;
      hrdf    <= 1'b0;
      tx_word <= '0;
      hrx     <= '0;
    end else begin
      txde    <= h2d ? 1'b1 : txde_a;
      hrdf    <= h2d ? 1'b1 : hrdf_a;
      tx_word <= pend_word;
      if (h2d) hrx <= pend_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htde    <= 1'b1;
      rxdf    <= 1'b0;
      htx     <= '0;
      rx_word <= '0;
    end else begin
      htde <= d2h ? 1'b1 : htde_a;
      rxdf <= d2h ? 1'b1 : rxdf_a;
      htx  <= htx_n;
      if (d2h) rx_word <= htx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot       <= 1'b1;
      boot_addr  <= '0;
      pmem_we    <= 1'b0;
      pmem_addr  <= '0;
      pmem_wdata <= '0;
    end else begin
      pmem_we <= boot_wr;
      if (boot_wr) begin
        pmem_addr  <= boot_addr;
        pmem_wdata <= wr_word;
        boot_addr  <= boot_addr + 1'b1;
        if (boot_last) boot <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_cnt <= '0;
    else if (acc & hst_cont)   wait_cnt <= WC_W'(WAIT_CYC);
    else if (wait_cnt != '0)   wait_cnt <= wait_cnt - 1'b1;
  end

endmodule

// File: rtl/host_mailbox_port_chk.sv
module host_mailbox_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc,
  input logic        hst_cont,
  input logic        hst_busy,
  input logic        wr_lo,
  input logic        rd_lo,
  input logic        dsp_rd_hrx,
  input logic        dsp_wr_htx,
  input logic [23:0] dsp_htx_wdata,
  input logic        boot,
  input logic        txde,
  input logic        hrdf,
  input logic        rxdf,
  input logic        htde,
  input logic [23:0] rx_word,
  input logic        dsp_run
);

  assert_h2d_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !boot && !hrdf) |=> (hrdf && txde));

  assert_h2d_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!txde && hrdf && !dsp_rd_hrx) |=> (!txde && hrdf));

  assert_d2h_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr_htx && !rxdf) |=> (rxdf && htde && rx_word == $past(dsp_htx_wdata)));

  assert_boot_keeps_rxdf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (boot && rd_lo && rxdf) |=> rxdf);

  assert_run_after_boot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_run |-> !boot);

  assert_run_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_run |=> dsp_run);

  assert_wait_starts_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hst_cont) |=> hst_busy);

endmodule

bind host_mailbox_port host_mailbox_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .hst_cont(hst_cont), .hst_busy(hst_busy),
  .wr_lo(wr_lo), .rd_lo(rd_lo), .dsp_rd_hrx(dsp_rd_hrx), .dsp_wr_htx(dsp_wr_htx),
  .dsp_htx_wdata(dsp_htx_wdata), .boot(boot), .txde(txde), .hrdf(hrdf),
  .rxdf(rxdf), .htde(htde), .rx_word(rx_word), .dsp_run(dsp_run)
);

// File: tb/test_host_mailbox_port.sv
module test_host_mailbox_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_sel = 1'b0, hst_wr = 1'b0, hst_cont = 1'b0, hst_iack = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic [7:0]  hst_wdata = '0;
  logic [7:0]  hst_rdata, hst_iack_vec, dsp_hsr;
  logic        hst_busy, hst_irq, hst_iack_spur, dsp_run, pmem_we;
  logic        dsp_rd_hrx = 1'b0, dsp_wr_htx = 1'b0;
  logic [23:0] dsp_htx_wdata = '0;
  logic [23:0] dsp_hrx, pmem_wdata;
  logic [8:0]  pmem_addr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  host_mailbox_port i_host_mailbox_port (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_cont(hst_cont),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_busy(hst_busy),
    .hst_irq(hst_irq), .hst_iack(hst_iack), .hst_iack_vec(hst_iack_vec),
    .hst_iack_spur(hst_iack_spur), .dsp_rd_hrx(dsp_rd_hrx), .dsp_hrx(dsp_hrx),
    .dsp_wr_htx(dsp_wr_htx), .dsp_htx_wdata(dsp_htx_wdata), .dsp_hsr(dsp_hsr),
    .dsp_run(dsp_run), .pmem_we(pmem_we), .pmem_addr(pmem_addr), .pmem_wdata(pmem_wdata)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d, input logic cont = 1'b0);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d; hst_cont = cont;
    @(negedge clk);
    hst_sel = 1'b0; hst_wr = 1'b0; hst_cont = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = a;
    #1 d = hst_rdata;
    @(negedge clk);
    hst_sel = 1'b0;
  endtask

  task automatic host_word(input logic [23:0] w);
    host_wr(3'd5, w[23:16]);
    host_wr(3'd6, w[15:8]);
    host_wr(3'd7, w[7:0]);
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  task automatic dsp_read(output logic [23:0] v);
    @(negedge clk);
    dsp_rd_hrx = 1'b1;
    #1 v = dsp_hrx;
    @(negedge clk);
    dsp_rd_hrx = 1'b0;
  endtask

  task automatic dsp_write(input logic [23:0] v);
    @(negedge clk);
    dsp_wr_htx = 1'b1; dsp_htx_wdata = v;
    @(negedge clk);
    dsp_wr_htx = 1'b0;
  endtask

  task automatic iack(output logic [7:0] vec, output logic spur);
    @(negedge clk);
    hst_iack = 1'b1;
    #1 vec = hst_iack_vec; spur = hst_iack_spur;
    @(negedge clk);
    hst_iack = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] b;
    peek(3'd2, b); check("R1", "status after reset", b, 8'h06);
    check("R1", "core status after reset", dsp_hsr, 8'h02);
    peek(3'd3, b); check("R1", "vector after reset", b, 8'h0F);
    check("R1", "run/busy/irq after reset", {dsp_run, hst_busy, hst_irq}, 3'b000);
  endtask

  task automatic t_regs;
    logic [7:0] b;
    host_wr(3'd1, 8'h5A); peek(3'd1, b); check("R2", "command vector readback", b, 8'h5A);
    host_wr(3'd3, 8'h40); peek(3'd3, b); check("R2", "vector readback", b, 8'h40);
    host_wr(3'd2, 8'hFF); peek(3'd2, b); check("R2", "status write ignored", b, 8'h06);
    host_wr(3'd4, 8'hFF); peek(3'd4, b); check("R2", "offset 4 reads zero", b, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] b;
    host_wr(3'd0, 8'hFF); peek(3'd0, b); check("R3", "control bit 2 forced low", b, 8'hFB);
    check("R3", "host flags on core status", dsp_hsr, 8'h1A);
    host_wr(3'd0, 8'h00);
    check("R3", "host flags cleared", dsp_hsr, 8'h02);
  endtask

  task automatic t_boot_out;
    logic [7:0] b;
    dsp_write(24'h123456);
    peek(3'd5, b); check("R6", "high byte", b, 8'h12);
    peek(3'd6, b); check("R6", "middle byte", b, 8'h34);
    peek(3'd7, b); check("R6", "low byte", b, 8'h56);
    peek(3'd2, b); check("R6", "host receive-full set", b, 8'h07);
    check("R6", "core transmit-empty set", dsp_hsr, 8'h02);
    host_rd(3'd7, b);
    peek(3'd2, b); check("R11", "boot low read keeps receive-full", b, 8'h07);
    dsp_write(24'hABCDEF);
    check("R7", "core word waits, transmit-empty clear", dsp_hsr, 8'h00);
    peek(3'd5, b); check("R7", "old word still visible", b, 8'h12);
  endtask

  task automatic t_boot;
    logic [7:0] b;
    int bad = 0;
    for (int i = 0; i < 512; i++) begin
      logic [23:0] w;
      w = 24'h5A0000 + 24'(i * 7);
      if (i == 511) check("R10", "run low before last word", dsp_run, 1'b0);
      host_word(w);
      if (pmem_we !== 1'b1 || pmem_addr !== 9'(i) || pmem_wdata !== w) bad++;
      if (i == 0) begin
        peek(3'd2, b); check("R9", "transmit-empty stays set in boot", b, 8'h07);
      end
    end
    check("R9", "boot words mismatched", bad, 0);
    check("R10", "run after last word", dsp_run, 1'b1);
    check("R9", "receive-full untouched by boot", dsp_hsr[0], 1'b0);
    check("R9", "receive word untouched by boot", dsp_hrx, 24'h0);
    @(negedge clk);
    check("R9", "write strobe drops", pmem_we, 1'b0);
  endtask

  task automatic t_out_pending;
    logic [7:0] b, v;
    logic s;
    host_wr(3'd0, 8'h01);
    check("R12", "request from receive-full", hst_irq, 1'b1);
    iack(v, s); check("R12", "acknowledge vector", {s, v}, 9'h040);
    host_rd(3'd7, b);
    check("R7", "low byte read before hand-off", b, 8'h56);
    peek(3'd5, b); check("R7", "waiting word moved high", b, 8'hAB);
    peek(3'd7, b); check("R7", "waiting word moved low", b, 8'hEF);
    check("R7", "core transmit-empty set again", dsp_hsr, 8'h02);
    host_rd(3'd7, b);
    peek(3'd2, b); check("R7", "receive-full cleared by read", b, 8'h06);
    check("R12", "request drops", hst_irq, 1'b0);
    iack(v, s); check("R12", "spurious acknowledge", {s, v}, 9'h100);
    host_wr(3'd0, 8'h02);
    check("R12", "request from transmit-empty", hst_irq, 1'b1);
    host_wr(3'd0, 8'h00);
  endtask

  task automatic t_in;
    logic [7:0] b;
    logic [23:0] v;
    host_wr(3'd5, 8'h11);
    peek(3'd2, b); check("R4", "partial word leaves status", b, 8'h06);
    host_wr(3'd6, 8'h22); host_wr(3'd7, 8'h33);
    check("R4", "receive word", dsp_hrx, 24'h112233);
    check("R4", "receive-full set", dsp_hsr, 8'h03);
    peek(3'd2, b); check("R8", "ready low while receive-full", b, 8'h02);
    dsp_read(v);
    peek(3'd2, b); check("R8", "ready back after core read", b, 8'h06);
  endtask

  task automatic t_in_pending;
    logic [7:0] b;
    logic [23:0] v;
    host_word(24'h445566);
    host_word(24'h778899);
    peek(3'd2, b); check("R5", "word waits, transmit-empty clear", b, 8'h00);
    dsp_read(v); check("R5", "first word read", v, 24'h445566);
    check("R5", "waiting word moved on read", dsp_hrx, 24'h778899);
    peek(3'd2, b); check("R5", "transmit-empty set again", b, 8'h02);
    dsp_read(v);
    peek(3'd2, b); check("R8", "idle status", b, 8'h06);
  endtask

  task automatic t_wait;
    logic [7:0] b;
    int n = 0;
    host_wr(3'd1, 8'h11);
    host_wr(3'd1, 8'h22, 1'b1);
    for (int i = 0; i < 8; i++) begin
      if (hst_busy) n++;
      @(negedge clk);
    end
    check("R13", "wait cycles", n, 4);
    host_wr(3'd1, 8'h22, 1'b1);
    host_wr(3'd1, 8'h33);
    repeat (6) @(negedge clk);
    peek(3'd1, b); check("R13", "write during wait ignored", b, 8'h22);
  endtask

  task automatic run_all;
    t_reset(); t_regs(); t_ctrl(); t_boot_out(); t_boot();
    t_out_pending(); t_in(); t_in_pending(); t_wait();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule